// File: doc/BRIEF.md
# Task-File Disk Command Controller

This block presents a small disk device to a host as a set of byte registers in the classic task-file layout. The registers are packed into two 32-bit words, and each byte lane carries one register. The host loads a sector count, an address and a command. It then moves sector data one 32-bit dword at a time through the data word while the block signals data-request. The block understands five opcodes: identify, single-sector read, block read, single-sector write and block-size set. Any other opcode is rejected with an abort error.

Each sector is 128 dwords and goes through a 128-dword buffer. The block does not talk to a disk. It drives a simple memory-mapped control master toward a storage back end. It polls a status address until the back end reports idle (value 2), then writes a start code. It then polls again until the back end is idle once more, which marks the end of the transfer. The back end fills or drains the buffer through its own slave port. Identify data is loaded from outside into a separate 128-dword store. A small device-control port gives soft reset and interrupt masking.

Top module: `ata_pio_ctrl`

## Requirements
- R1: After reset the status byte reads 0x40 and irq is low. The status byte has busy in bit 7, ready in bit 6, data-request in bit 3 and error in bit 0. Busy and data-request are never both set.
- R2: Register layout:
  - Word 1 lane 0 holds cylinder low, lane 1 holds cylinder high, lane 2 holds drive/head, and lane 3 is command on write and status on read.
  - Word 0 lane 2 holds sector count and lane 3 holds sector number.
  - A word-0 access with all four byte enables is a data dword. Such a read returns zero when no transfer is active.
  - Read data appears on hostRdata the cycle after the read strobe.
- R3: Opcode 0xEC sets data-request and raises the interrupt in the next cycle. The next 128 data reads return the identify store in index order, after which status returns to 0x40.
- R4: Opcode 0x21 sets busy in the next cycle. The master polls address 4 until it reads 2, writes 2 to address 12, and polls address 4 until it reads 2 again. Then data-request and the interrupt assert, and 128 data reads return the buffer in index order. This repeats for each sector of the count.
- R5: A sector count of 0 transfers 256 sectors.
- R6: Opcode 0x30 sets data-request at once with no interrupt. After 128 data writes the buffer holds them in order. The block then starts the back end with code 3 and raises the interrupt when it finishes. Data-request returns for the next sector if one remains; otherwise status returns to 0x40.
- R7: Opcode 0xC6 stores the sector count as block size M and raises the interrupt. Opcode 0x29 reads like 0x21 but interrupts only on the first sector of each group of M. It aborts when M is 0.
- R8: Any other opcode sets error in status, sets bit 2 of the error register (read on word 0 lane 1) and raises the interrupt. The next accepted command clears both.
- R9: A host read of word 1 with lane 3 enabled clears the pending interrupt. Reading status on the device-control port does not clear it.
- R10: Device-control bit 1 masks irq without discarding a pending interrupt.
- R11: Device-control bit 2 aborts any command and clears the pending interrupt and the error; status returns to 0x40.
- R12: A command written while the block is not idle is ignored.
- R13: A master read or write held while beWaitReq is high stays asserted with an unchanged address. Each start code is issued exactly once per sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low reset |
| hostAddr | input | 1 | host word address |
| hostBe | input | 4 | host byte enables |
| hostRd | input | 1 | host read strobe |
| hostWr | input | 1 | host write strobe |
| hostWdata | input | 32 | host write data |
| hostRdata | output | 32 | host read data, registered |
| devCtlWr | input | 1 | device-control write |
| devCtlWdata | input | 8 | device-control data (bit 1 mask, bit 2 reset) |
| devCtlRdata | output | 8 | status without interrupt clear |
| irq | output | 1 | interrupt request |
| beAddr | output | 32 | back-end control address |
| beRd | output | 1 | back-end read request |
| beWr | output | 1 | back-end write request |
| beWdata | output | 32 | back-end write data |
| beWaitReq | input | 1 | back-end stall |
| beRdValid | input | 1 | back-end read data valid |
| beRdata | input | 32 | back-end read data |
| bufAddr | input | 9 | buffer slave address |
| bufRd | input | 1 | buffer slave read |
| bufWr | input | 1 | buffer slave write |
| bufWdata | input | 32 | buffer slave write data |
| bufRdata | output | 32 | buffer slave read data, registered |
| idWr | input | 1 | identify store write |
| idAddr | input | 7 | identify store index |
| idData | input | 32 | identify store data |

## Verification
A wrong buffer pointer shows up within one sector. The dwords come back shifted or from the wrong sector, or the transfer ends early or late, so data-request drops at the wrong dword. A corrupted sector-remaining count surfaces at the last sector: the block either stops before the expected count or asks for an extra sector. The 256-sector case exposes a count that is one bit too narrow. A wrong interrupt or error state is visible on irq and in the status byte in the cycle right after the command or completion that should set it.

// File: rtl/ata_pkg.sv
package ata_pkg;
  localparam int DW = 32;
  localparam int AW = 32;
  localparam logic [AW-1:0] BE_STAT_ADDR = 32'd4;
  localparam logic [AW-1:0] BE_GO_ADDR   = 32'd12;
  localparam logic [DW-1:0] BE_IDLE      = 32'd2;
  localparam logic [DW-1:0] GO_READ      = 32'd2;
  localparam logic [DW-1:0] GO_WRITE     = 32'd3;

  localparam logic [7:0] OP_IDENT    = 8'hEC;
  localparam logic [7:0] OP_READ     = 8'h21;
  localparam logic [7:0] OP_READMULT = 8'h29;
  localparam logic [7:0] OP_WRITE    = 8'h30;
  localparam logic [7:0] OP_SETMULT  = 8'hC6;

  typedef enum logic [2:0] {
    S_IDLE, S_HOST, S_POLLREQ, S_POLLRSP, S_START
  } state_t;

  typedef struct packed {
    logic xferEn;
    logic xferWr;
    logic idSel;
    logic ptrClr;
    logic setMult;
    logic setAbort;
    logic clrErr;
  } strobe_t;
endpackage

// File: rtl/ata_datapath.sv
module ata_datapath
  import ata_pkg::*;
#(
  parameter int WORDS = 128,
  parameter int BUFAW = 9,
  localparam int PTRW = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic [7:0]      statusByte,
  input  logic            hostAddr,
  input  logic [3:0]      hostBe,
  input  logic            hostRd,
  input  logic            hostWr,
  input  logic [DW-1:0]   hostWdata,
  output logic [DW-1:0]   hostRdata,
  input  logic [BUFAW-1:0] bufAddr,
  input  logic            bufRd,
  input  logic            bufWr,
  input  logic [DW-1:0]   bufWdata,
  output logic [DW-1:0]   bufRdata,
  input  logic            idWr,
  input  logic [PTRW-1:0] idAddr,
  input  logic [DW-1:0]   idData,
  output logic            cmdStrobe,
  output logic [7:0]      cmdCode,
  output logic [7:0]      secCnt,
  output logic [7:0]      multCnt,
  output logic            lastDword,
  output logic            statusRead
);
  logic [DW-1:0] secBuf [WORDS];
  logic [DW-1:0] idMem  [WORDS];
  logic [PTRW-1:0] ptr;
  logic [7:0] secNum, cylLo, cylHi, devHead, errReg;
  logic dataRd, dataWr, xferAcc, bufHit;

  assign dataRd    = hostRd && !hostAddr && (&hostBe);
  assign dataWr    = hostWr && !hostAddr && (&hostBe);
  assign xferAcc   = stb.xferEn && ((dataRd && !stb.xferWr) || (dataWr && stb.xferWr));
  assign lastDword = xferAcc && (ptr == PTRW'(WORDS - 1));
  assign cmdStrobe = hostWr && hostAddr && hostBe[3];
  assign cmdCode   = hostWdata[31:24];
  assign statusRead = hostRd && hostAddr && hostBe[3];
  assign bufHit    = bufAddr < BUFAW'(WORDS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptr <= '0;
    else if (stb.ptrClr) ptr <= '0;
    else if (xferAcc) ptr <= ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (xferAcc && stb.xferWr) secBuf[ptr] <= hostWdata;
    else if (bufWr && bufHit) secBuf[bufAddr[PTRW-1:0]] <= bufWdata;
    if (idWr) idMem[idAddr] <= idData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bufRdata <= '0;
    else if (bufRd) bufRdata <= bufHit ? secBuf[bufAddr[PTRW-1:0]] : '0;
  end

  // task-file byte registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secCnt <= '0; secNum <= '0; cylLo <= '0; cylHi <= '0;
      devHead <= '0; errReg <= '0; multCnt <= '0;
    end else begin
      if (hostWr && !hostAddr && !dataWr) begin
        if (hostBe[2]) secCnt <= hostWdata[23:16];
        if (hostBe[3]) secNum <= hostWdata[31:24];
      end
      if (hostWr && hostAddr) begin
        if (hostBe[0]) cylLo   <= hostWdata[7:0];
        if (hostBe[1]) cylHi   <= hostWdata[15:8];
        if (hostBe[2]) devHead <= hostWdata[23:16];
      end
      if (stb.setMult) multCnt <= secCnt;
      if (stb.setAbort) errReg <= 8'h04;
      else if (stb.clrErr) errReg <= 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hostRdata <= '0;
    else if (hostRd) begin
      if (hostAddr) hostRdata <= {statusByte, devHead, cylHi, cylLo};
      else if (&hostBe) hostRdata <= xferAcc ? (stb.idSel ? idMem[ptr] : secBuf[ptr]) : '0;
      else hostRdata <= {secNum, secCnt, errReg, 8'h00};
    end
  end

  // a data read outside a transfer yields zero
  assert_idle_data_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && !stb.xferEn) |=> (hostRdata == '0));
  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!hostRd && !hostWr && !stb.ptrClr) |=> $stable(ptr));
endmodule

// File: rtl/ata_ctrl.sv
module ata_ctrl
  import ata_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdStrobe,
  input  logic [7:0]    cmdCode,
  input  logic [7:0]    secCnt,
  input  logic [7:0]    multCnt,
  input  logic          lastDword,
  input  logic          statusRead,
  input  logic          devCtlWr,
  input  logic [7:0]    devCtlWdata,
  output strobe_t       stb,
  output logic [7:0]    statusByte,
  output logic          irq,
  output logic [AW-1:0] beAddr,
  output logic          beRd,
  output logic          beWr,
  output logic [DW-1:0] beWdata,
  input  logic          beWaitReq,
  input  logic          beRdValid,
  input  logic [DW-1:0] beRdata
);
  state_t state;
  logic started, dirWr, idMode, multi, err, irqPend, nIen, srst;
  logic [8:0] remain, blockLeft, cnt9;
  logic accept, rspIdle, readDone, writeDone, badCmd, blockStart, irqSet, bsy, drq;
  logic unusedCtlBits;

  assign unusedCtlBits = ^{devCtlWdata[7:3], devCtlWdata[0]};
  assign cnt9      = (secCnt == 8'd0) ? 9'd256 : {1'b0, secCnt};
  assign accept    = cmdStrobe && (state == S_IDLE) && !srst;
  assign rspIdle   = (state == S_POLLRSP) && beRdValid && (beRdata == BE_IDLE);
  assign readDone  = rspIdle && started && !dirWr;
  assign writeDone = rspIdle && started && dirWr;
  assign blockStart = multi ? (blockLeft == 9'd0) : 1'b1;

  always_comb begin
    case (cmdCode)
      OP_IDENT, OP_READ, OP_WRITE, OP_SETMULT: badCmd = 1'b0;
      OP_READMULT: badCmd = (multCnt == 8'd0);
      default: badCmd = 1'b1;
    endcase
  end

  assign irqSet = (accept && (cmdCode == OP_IDENT || cmdCode == OP_SETMULT || badCmd))
                || (readDone && blockStart) || writeDone;

  always_comb begin
    stb.xferEn   = (state == S_HOST);
    stb.xferWr   = dirWr;
    stb.idSel    = idMode;
    stb.ptrClr   = srst || accept || readDone || writeDone;
    stb.setMult  = accept && (cmdCode == OP_SETMULT);
    stb.setAbort = accept && badCmd;
    stb.clrErr   = srst || (accept && !badCmd);
  end

  assign bsy = (state == S_POLLREQ) || (state == S_POLLRSP) || (state == S_START);
  assign drq = (state == S_HOST);
  assign statusByte = {bsy, !bsy, 2'b00, drq, 2'b00, err};
  assign irq     = irqPend && !nIen;
  assign beRd    = (state == S_POLLREQ);
  assign beWr    = (state == S_START);
  assign beAddr  = beWr ? BE_GO_ADDR : BE_STAT_ADDR;
  assign beWdata = dirWr ? GO_WRITE : GO_READ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nIen <= 1'b0; srst <= 1'b0; irqPend <= 1'b0;
    end else begin
      if (devCtlWr) begin
        nIen <= devCtlWdata[1];
        srst <= devCtlWdata[2];
      end
      irqPend <= srst ? 1'b0 : (irqSet || (irqPend && !statusRead));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; started <= 1'b0; dirWr <= 1'b0; idMode <= 1'b0;
      multi <= 1'b0; err <= 1'b0; remain <= '0; blockLeft <= '0;
    end else if (srst) begin
      state <= S_IDLE; started <= 1'b0; dirWr <= 1'b0; idMode <= 1'b0;
      multi <= 1'b0; err <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          err <= badCmd;
          if (!badCmd) begin
            case (cmdCode)
              OP_IDENT: begin state <= S_HOST; dirWr <= 1'b0; idMode <= 1'b1; end
              OP_READ, OP_READMULT: begin
                state <= S_POLLREQ; dirWr <= 1'b0; started <= 1'b0; remain <= cnt9;
                multi <= (cmdCode == OP_READMULT); blockLeft <= '0;
              end
              OP_WRITE: begin state <= S_HOST; dirWr <= 1'b1; remain <= cnt9; end
              default: ;
            endcase
          end
        end
        S_POLLREQ: if (!beWaitReq) state <= S_POLLRSP;
        S_POLLRSP: if (beRdValid) begin
          if (beRdata != BE_IDLE) state <= S_POLLREQ;
          else if (!started) state <= S_START;
          else if (dirWr) begin
            remain <= remain - 1'b1;
            state  <= (remain == 9'd1) ? S_IDLE : S_HOST;
          end else begin
            state <= S_HOST;
            if (multi) blockLeft <= blockStart ? ({1'b0, multCnt} - 1'b1) : (blockLeft - 1'b1);
          end
        end
        S_START: if (!beWaitReq) begin started <= 1'b1; state <= S_POLLREQ; end
        S_HOST: if (lastDword) begin
          if (idMode) begin state <= S_IDLE; idMode <= 1'b0; end
          else if (dirWr) begin state <= S_POLLREQ; started <= 1'b0; end
          else begin
            remain <= remain - 1'b1;
            started <= 1'b0;
            state <= (remain == 9'd1) ? S_IDLE : S_POLLREQ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_bsy_drq_excl_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(statusByte[7] && statusByte[3]));
  assert_rdwr_excl_R13: assert property (@(posedge clk) disable iff (!rstN)
    !(beRd && beWr));
  assert_rd_held_R13: assert property (@(posedge clk) disable iff (!rstN)
    (beRd && beWaitReq) |=> (beRd && $stable(beAddr)));
  assert_wr_held_R13: assert property (@(posedge clk) disable iff (!rstN)
    (beWr && beWaitReq) |=> (beWr && $stable(beAddr) && $stable(beWdata)));
  assert_srst_clears_R11: assert property (@(posedge clk) disable iff (!rstN)
    srst |=> (statusByte == 8'h40 && !irqPend));
  assert_busy_cmd_ignored_R12: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStrobe && state != S_IDLE && !srst) |=> !statusByte[0]);
  assert_status_read_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !irqSet) |=> !irqPend);
endmodule

// File: rtl/ata_pio_ctrl.sv
module ata_pio_ctrl
  import ata_pkg::*;
#(
  parameter int WORDS = 128,
  parameter int BUFAW = 9,
  localparam int PTRW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostAddr,
  input  logic [3:0]       hostBe,
  input  logic             hostRd,
  input  logic             hostWr,
  input  logic [31:0]      hostWdata,
  output logic [31:0]      hostRdata,
  input  logic             devCtlWr,
  input  logic [7:0]       devCtlWdata,
  output logic [7:0]       devCtlRdata,
  output logic             irq,
  output logic [31:0]      beAddr,
  output logic             beRd,
  output logic             beWr,
  output logic [31:0]      beWdata,
  input  logic             beWaitReq,
  input  logic             beRdValid,
  input  logic [31:0]      beRdata,
  input  logic [BUFAW-1:0] bufAddr,
  input  logic             bufRd,
  input  logic             bufWr,
  input  logic [31:0]      bufWdata,
  output logic [31:0]      bufRdata,
  input  logic             idWr,
  input  logic [PTRW-1:0]  idAddr,
  input  logic [31:0]      idData
);
  strobe_t stb;
  logic [7:0] statusByte, cmdCode, secCnt, multCnt;
  logic cmdStrobe, lastDword, statusRead;

  assign devCtlRdata = statusByte;

  ata_ctrl uCtrl (
    .clk, .rstN, .cmdStrobe, .cmdCode, .secCnt, .multCnt, .lastDword, .statusRead,
    .devCtlWr, .devCtlWdata, .stb, .statusByte, .irq,
    .beAddr, .beRd, .beWr, .beWdata, .beWaitReq, .beRdValid, .beRdata
  );

  ata_datapath #(.WORDS(WORDS), .BUFAW(BUFAW)) uDp (
    .clk, .rstN, .stb, .statusByte,
    .hostAddr, .hostBe, .hostRd, .hostWr, .hostWdata, .hostRdata,
    .bufAddr, .bufRd, .bufWr, .bufWdata, .bufRdata,
    .idWr, .idAddr, .idData,
    .cmdStrobe, .cmdCode, .secCnt, .multCnt, .lastDword, .statusRead
  );
endmodule

// File: tb/sim_ata_pio_ctrl.sv
`timescale 1ns/1ps
module sim_ata_pio_ctrl;
  logic clk = 1'b0, rstN = 1'b0;
  logic hostAddr = 1'b0, hostRd = 1'b0, hostWr = 1'b0;
  logic [3:0] hostBe = '0;
  logic [31:0] hostWdata = '0, hostRdata;
  logic devCtlWr = 1'b0;
  logic [7:0] devCtlWdata = '0, devCtlRdata;
  logic irq, beRd, beWr, beWaitReq, beRdValid = 1'b0;
  logic [31:0] beAddr, beWdata, beRdata = '0;
  logic [8:0] bufAddr = '0;
  logic bufRd = 1'b0, bufWr = 1'b0;
  logic [31:0] bufWdata = '0, bufRdata;
  logic idWr = 1'b0;
  logic [6:0] idAddr = '0;
  logic [31:0] idData = '0;

  int checks = 0, errors = 0;
  int startCnt = 0, lastCode = 0, protoErr = 0, drainBad = 0;
  int rdSecFill = 0, rdSecHost = 0, wrSecHost = 0, wrSecDrain = 0;
  bit busy = 1'b0, holdDone = 1'b0;

  always #10 clk = ~clk;

  ata_pio_ctrl u0 (.*);

  function automatic logic [31:0] rdPat(int s, int i); return 32'hA000_0000 | (s << 8) | i; endfunction
  function automatic logic [31:0] wrPat(int s, int i); return 32'h5000_0000 | (s << 8) | i; endfunction
  function automatic logic [31:0] idPat(int i); return 32'h1D00_0000 | (i * 3); endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // back-end model: one wait cycle on every request, status 1 while busy, 2 when idle
  assign beWaitReq = (beRd | beWr) & ~holdDone;
  always @(posedge clk) begin
    holdDone  <= (beRd | beWr) & ~holdDone;
    beRdValid <= beRd && !beWaitReq;
    beRdata   <= busy ? 32'd1 : 32'd2;
  end

  initial begin : backEnd
    int code;
    forever begin
      @(negedge clk);
      if (beWr && !beWaitReq) begin
        if (busy || beAddr != 32'd12) protoErr++;
        startCnt++; code = beWdata; lastCode = code; busy = 1'b1;
        if (code == 2) begin
          for (int i = 0; i < 128; i++) begin
            @(negedge clk); bufWr = 1'b1; bufAddr = 9'(i); bufWdata = rdPat(rdSecFill, i);
          end
          @(negedge clk); bufWr = 1'b0; rdSecFill++;
        end else begin
          for (int i = 0; i <= 128; i++) begin
            @(negedge clk);
            if (i > 0 && bufRdata !== wrPat(wrSecDrain, i - 1)) drainBad++;
            if (i < 128) begin bufRd = 1'b1; bufAddr = 9'(i); end else bufRd = 1'b0;
          end
          wrSecDrain++;
        end
        busy = 1'b0;
      end
    end
  end

  task automatic hwr(bit a, logic [3:0] be, logic [31:0] d);
    @(negedge clk); hostAddr = a; hostBe = be; hostWdata = d; hostWr = 1'b1;
    @(negedge clk); hostWr = 1'b0;
  endtask

  task automatic hrd(bit a, logic [3:0] be, output logic [31:0] d);
    @(negedge clk); hostAddr = a; hostBe = be; hostRd = 1'b1;
    @(negedge clk); hostRd = 1'b0; d = hostRdata;
  endtask

  task automatic ctlWr(logic [7:0] d);
    @(negedge clk); devCtlWdata = d; devCtlWr = 1'b1;
    @(negedge clk); devCtlWr = 1'b0;
  endtask

  task automatic waitDrq();
    for (int k = 0; k < 3000; k++) begin
      if (devCtlRdata[3]) break;
      @(negedge clk);
    end
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 3000; k++) begin
      if (devCtlRdata == 8'h40 || devCtlRdata == 8'h41) break;
      @(negedge clk);
    end
  endtask

  // back-to-back data reads; returns mismatch count
  task automatic readBlock(bit isId, output int bad);
    bad = 0;
    @(negedge clk); hostAddr = 1'b0; hostBe = 4'hF; hostRd = 1'b1;
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      if (i == 127) hostRd = 1'b0;
      if (hostRdata !== (isId ? idPat(i) : rdPat(rdSecHost, i))) bad++;
    end
    if (!isId) rdSecHost++;
  endtask

  task automatic writeBlock();
    for (int i = 0; i < 128; i++) begin
      @(negedge clk); hostAddr = 1'b0; hostBe = 4'hF; hostWdata = wrPat(wrSecHost, i); hostWr = 1'b1;
    end
    @(negedge clk); hostWr = 1'b0; wrSecHost++;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin : main
    logic [31:0] d;
    int bad, s0, secs;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(devCtlRdata == 8'h40, "R1 reset status", devCtlRdata, 8'h40);
    chk(irq == 1'b0, "R1 reset irq", irq, 0);

    // R2 register layout
    hwr(1'b1, 4'b0111, 32'h00E5_3412);
    hrd(1'b1, 4'b0111, d);
    chk(d[23:0] == 24'hE53412, "R2 word1 lanes", d[23:0], 24'hE53412);
    hwr(1'b0, 4'b1100, 32'h0702_0000);
    hrd(1'b0, 4'b1100, d);
    chk(d[31:16] == 16'h0702, "R2 count/sector lanes", d[31:16], 16'h0702);
    hrd(1'b0, 4'hF, d);
    chk(d == 0, "R2 idle data read", d, 0);

    // R3 identify
    for (int i = 0; i < 128; i++) begin
      @(negedge clk); idWr = 1'b1; idAddr = 7'(i); idData = idPat(i);
    end
    @(negedge clk); idWr = 1'b0;
    hwr(1'b1, 4'b1000, 32'hEC00_0000);
    chk(devCtlRdata == 8'h48, "R3 identify drq", devCtlRdata, 8'h48);
    chk(irq == 1'b1, "R3 identify irq", irq, 1);
    @(negedge clk);
    chk(irq == 1'b1, "R9 alt status keeps irq", irq, 1);
    hrd(1'b1, 4'b1000, d);
    chk(d[31:24] == 8'h48 && irq == 1'b0, "R9 status read clears irq", {d[31:24], 7'd0, irq}, 16'h4800);
    readBlock(1'b1, bad);
    chk(bad == 0, "R3 identify data", bad, 0);
    chk(devCtlRdata == 8'h40, "R3 identify end", devCtlRdata, 8'h40);

    // R4 read two sectors, R12 command while busy
    s0 = startCnt;
    hwr(1'b0, 4'b0100, 32'h0002_0000);
    hwr(1'b1, 4'b1000, 32'h2100_0000);
    chk(devCtlRdata == 8'h80, "R4 busy after read cmd", devCtlRdata, 8'h80);
    hwr(1'b1, 4'b1000, 32'h5500_0000);
    waitDrq();
    chk(irq == 1'b1 && devCtlRdata == 8'h48, "R4 drq+irq after fill", {devCtlRdata, 7'd0, irq}, 16'h4801);
    chk(startCnt - s0 == 1 && lastCode == 2, "R4 start code", lastCode, 2);
    hrd(1'b1, 4'b1000, d);
    readBlock(1'b0, bad);
    chk(bad == 0, "R4 sector 0 data", bad, 0);
    waitDrq();
    readBlock(1'b0, bad);
    chk(bad == 0, "R4 sector 1 data", bad, 0);
    chk(devCtlRdata == 8'h40, "R12 busy command ignored", devCtlRdata, 8'h40);
    chk(startCnt - s0 == 2 && protoErr == 0, "R13 one start per sector", startCnt - s0, 2);

    // R6 write two sectors
    s0 = startCnt;
    hrd(1'b1, 4'b1000, d);
    hwr(1'b1, 4'b1000, 32'h3000_0000);
    chk(devCtlRdata == 8'h48 && irq == 1'b0, "R6 write drq no irq", {devCtlRdata, 7'd0, irq}, 16'h4800);
    writeBlock();
    waitDrq();
    chk(irq == 1'b1 && lastCode == 3, "R6 sector done irq/code", {lastCode[7:0], 7'd0, irq}, 16'h0301);
    hrd(1'b1, 4'b1000, d);
    writeBlock();
    waitIdle();
    chk(devCtlRdata == 8'h40 && irq == 1'b1, "R6 write end", {devCtlRdata, 7'd0, irq}, 16'h4001);
    chk(drainBad == 0 && startCnt - s0 == 2, "R6 buffer content", drainBad, 0);
    hrd(1'b1, 4'b1000, d);

    // R7 set multiple 3, read multiple 4
    hwr(1'b0, 4'b0100, 32'h0003_0000);
    hwr(1'b1, 4'b1000, 32'hC600_0000);
    chk(devCtlRdata == 8'h40 && irq == 1'b1, "R7 set multiple", {devCtlRdata, 7'd0, irq}, 16'h4001);
    hrd(1'b1, 4'b1000, d);
    hwr(1'b0, 4'b0100, 32'h0004_0000);
    hwr(1'b1, 4'b1000, 32'h2900_0000);
    for (int k = 0; k < 4; k++) begin
      waitDrq();
      chk(irq == ((k == 0 || k == 3) ? 1'b1 : 1'b0), "R7 block irq pattern", irq, (k == 0 || k == 3));
      hrd(1'b1, 4'b1000, d);
      readBlock(1'b0, bad);
      chk(bad == 0, "R7 block read data", bad, 0);
    end
    chk(devCtlRdata == 8'h40, "R7 block read end", devCtlRdata, 8'h40);
    hwr(1'b0, 4'b0100, 32'h0000_0000);
    hwr(1'b1, 4'b1000, 32'hC600_0000);
    hwr(1'b0, 4'b0100, 32'h0001_0000);
    hwr(1'b1, 4'b1000, 32'h2900_0000);
    chk(devCtlRdata == 8'h41, "R7 zero block size aborts", devCtlRdata, 8'h41);

    // R8 unknown opcode
    hrd(1'b1, 4'b1000, d);
    hwr(1'b1, 4'b1000, 32'h5500_0000);
    chk(devCtlRdata == 8'h41 && irq == 1'b1, "R8 abort status", {devCtlRdata, 7'd0, irq}, 16'h4101);
    hrd(1'b0, 4'b0010, d);
    chk(d[15:8] == 8'h04, "R8 error register", d[15:8], 8'h04);
    hwr(1'b0, 4'b0100, 32'h0002_0000);
    hwr(1'b1, 4'b1000, 32'hC600_0000);
    hrd(1'b0, 4'b0010, d);
    chk(devCtlRdata == 8'h40 && d[15:8] == 8'h00, "R8 error cleared", {devCtlRdata, d[15:8]}, 16'h4000);
    hrd(1'b1, 4'b1000, d);

    // R10 mask
    ctlWr(8'h02);
    hwr(1'b1, 4'b1000, 32'h5500_0000);
    chk(irq == 1'b0, "R10 masked irq", irq, 0);
    ctlWr(8'h00);
    chk(irq == 1'b1, "R10 pending kept", irq, 1);
    hrd(1'b1, 4'b1000, d);

    // R11 soft reset during write
    hwr(1'b0, 4'b0100, 32'h0001_0000);
    hwr(1'b1, 4'b1000, 32'h3000_0000);
    ctlWr(8'h04);
    ctlWr(8'h00);
    chk(devCtlRdata == 8'h40 && irq == 1'b0, "R11 soft reset", {devCtlRdata, 7'd0, irq}, 16'h4000);

    // R5 count 0 = 256 sectors
    s0 = startCnt; secs = 0; bad = 0;
    hwr(1'b0, 4'b0100, 32'h0000_0000);
    hwr(1'b1, 4'b1000, 32'h2100_0000);
    do begin
      int b;
      waitDrq();
      readBlock(1'b0, b);
      bad += b; secs++;
    end while (devCtlRdata != 8'h40 && secs < 300);
    chk(secs == 256, "R5 sector count zero", secs, 256);
    chk(bad == 0 && startCnt - s0 == 256, "R5 data and starts", bad, 0);

    finishRun();
  end
endmodule